// File: doc/BRIEF.md
# Binary and Decimal Arithmetic Flag Unit

This block is the arithmetic core of a small 8-bit processor datapath. It adds with carry or subtracts with borrow on two bytes, the accumulator and an operand. The arithmetic runs either in plain binary or in packed two-digit decimal. The same unit also performs a bit test of the accumulator against the operand, and it increments or decrements the accumulator. For every operation it returns a result byte, the negative, overflow, zero and carry flag values, and one update enable per flag. The enable tells the surrounding status logic whether that flag should be written.

The datapath is combinational. A start strobe captures the operation's outcome into an output register, and a valid pulse follows exactly one clock later. Between strobes the registered outputs hold their last values. Operand fetch, the rest of the status register and instruction decode live outside the block.

Top module: `alu_bcd_core`

## Requirements
- R1: Binary add (op code 0, decimal flag low) gives res = (A + M + Cin) mod 256, with C set when the sum exceeds 255. V is bit 7 of (NOT(A XOR M)) AND (A XOR sum). N is res bit 7, and Z is set when res is zero.
- R2: Decimal add (op code 0, decimal flag high) forms a low digit sum lo = A[3:0] + M[3:0] + Cin and a high sum hi = A[7:4]*16 + M[7:4]*16. When lo > 9 it adds 6 to lo and 16 to hi. When hi then exceeds 0x90 it adds 0x60 to hi. C = (hi >= 0x100), res = {hi[7:4], lo[3:0]}, and N and Z follow res. With valid decimal operands, both digits of res are valid decimal digits.
- R3: In decimal add, V is the binary overflow formula applied to hi after the low-digit correction and before the 0x60 high correction.
- R4: Subtract (op code 1) forms t = A - M - (1 - Cin) modulo 65536. V is bit 7 of (A XOR t) AND (A XOR M), and C = ((A - (1 - Cin)) >= M) as signed integers. In binary mode res = t[7:0], with N and Z from res.
- R5: In decimal subtract, 0x60 is taken from t when t > 0xFF. Then 6 is taken from t when A[3:0] - M[3:0] - (1 - Cin) is negative. res is the low byte of the final t, and N and Z follow res. V and C are as in R4.
- R6: The bit test (op code 2, immediate flag low) leaves res = A. It updates Z = ((A AND M) == 0), N = M[7] and V = M[6], and it does not update C.
- R7: The bit test with the immediate flag high updates only Z. Its N, V and C update enables are low.
- R8: Increment (op code 3) and decrement (op code 4) return (A + 1) mod 256 and (A - 1) mod 256. They update only N and Z.
- R9: Add and subtract assert all four update enables. A flag output whose update enable is low reads 0.
- R10: Op codes 5, 6 and 7 leave res = A and assert no update enable.
- R11: res_valid is high in exactly the cycle after a cycle with start high. When start is low, all registered outputs hold their values.
- R12: After a synchronous active-low reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Capture the current operation into the output register |
| op | input | 3 | Operation: 0 add, 1 subtract, 2 bit test, 3 increment, 4 decrement |
| acc | input | 8 | Accumulator operand |
| opnd | input | 8 | Second operand |
| carry_in | input | 1 | Incoming carry (subtract: 1 means no borrow) |
| dec_mode | input | 1 | Decimal arithmetic for add and subtract |
| imm_mode | input | 1 | Bit test uses an immediate operand |
| res | output | 8 | Registered result byte |
| flag_n | output | 1 | Negative flag value |
| flag_v | output | 1 | Overflow flag value |
| flag_z | output | 1 | Zero flag value |
| flag_c | output | 1 | Carry flag value |
| upd_n | output | 1 | Write enable for N |
| upd_v | output | 1 | Write enable for V |
| upd_z | output | 1 | Write enable for Z |
| upd_c | output | 1 | Write enable for C |
| res_valid | output | 1 | One-cycle pulse after start |

## Verification
The digit-validity property for decimal add holds only when both operands consist of nibbles of 9 or less. The assertion therefore checks it only on such inputs. The random stimulus feeds arbitrary bytes, including non-decimal nibbles, in both modes, because the arithmetic is still fully defined for them. The output-hold and valid properties assume that start is driven low between operations. The bench inserts an idle cycle after every capture to keep to that pattern.

// File: rtl/alu_bcd_pkg.sv
// Shared widths, operation codes and the per-unit result bundle.
// Assumes an 8-bit datapath split into two 4-bit decimal digits.
package alu_bcd_pkg;
    localparam int DATA_W = 8;
    localparam int NIB_W  = DATA_W / 2;
    localparam int OP_W   = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_BIT = 3'd2,
        OP_INC = 3'd3,
        OP_DEC = 3'd4
    } alu_op_e;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              n;
        logic              v;
        logic              z;
        logic              c;
    } alu_out_t;
endpackage

// File: rtl/alu_add_unit.sv
// Add-with-carry in binary or packed decimal.
// Assumes the caller selects this unit's bundle only for the add operation.
module alu_add_unit
    import alu_bcd_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] m,
    input  logic              cin,
    input  logic              dec,
    output alu_out_t          y
);
    localparam int LO_W = NIB_W + 2;
    localparam int HI_W = DATA_W + 2;

    logic [DATA_W:0]     bsum;
    logic [LO_W-1:0]     lo_raw;
    logic [NIB_W-1:0]    lo_fix;
    logic [HI_W-1:0]     hi_raw, hi_mid, hi_fix;
    logic                lo_adj, hi_adj;
    logic [DATA_W-1:0]   dres;

    // Binary sum and decimal digit-corrected sum, then selection by mode.
    always_comb begin
        bsum   = {1'b0, a} + {1'b0, m} + (DATA_W+1)'(cin);
        lo_raw = {2'b00, a[NIB_W-1:0]} + {2'b00, m[NIB_W-1:0]} + LO_W'(cin);
        hi_raw = {2'b00, a[DATA_W-1:NIB_W], {NIB_W{1'b0}}}
               + {2'b00, m[DATA_W-1:NIB_W], {NIB_W{1'b0}}};
        lo_adj = lo_raw > LO_W'(9);
        lo_fix = lo_adj ? (lo_raw[NIB_W-1:0] + NIB_W'(6)) : lo_raw[NIB_W-1:0];
        hi_mid = lo_adj ? (hi_raw + HI_W'(16)) : hi_raw;
        hi_adj = hi_mid > HI_W'(144);
        hi_fix = hi_adj ? (hi_mid + HI_W'(96)) : hi_mid;
        dres   = hi_fix[DATA_W-1:0] + {{NIB_W{1'b0}}, lo_fix};
        if (dec) begin
            y.res = dres;
            y.v   = ~(a[DATA_W-1] ^ m[DATA_W-1]) & (a[DATA_W-1] ^ hi_mid[DATA_W-1]);
            y.c   = |hi_fix[HI_W-1:DATA_W];
        end else begin
            y.res = bsum[DATA_W-1:0];
            y.v   = ~(a[DATA_W-1] ^ m[DATA_W-1]) & (a[DATA_W-1] ^ bsum[DATA_W-1]);
            y.c   = bsum[DATA_W];
        end
        y.n = y.res[DATA_W-1];
        y.z = (y.res == '0);
    end
endmodule

// File: rtl/alu_sub_unit.sv
// Subtract-with-borrow in binary or packed decimal (carry high = no borrow).
// Assumes the caller selects this unit's bundle only for the subtract operation.
module alu_sub_unit
    import alu_bcd_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] m,
    input  logic              cin,
    input  logic              dec,
    output alu_out_t          y
);
    logic [DATA_W:0]   bdiff;
    logic              brw, wrap, lo_neg;
    logic [DATA_W-1:0] dres;

    // Raw difference, then optional decimal corrections on the low byte.
    always_comb begin
        brw    = ~cin;
        bdiff  = {1'b0, a} - {1'b0, m} - (DATA_W+1)'(brw);
        wrap   = bdiff[DATA_W];
        lo_neg = {1'b0, a[NIB_W-1:0]} < ({1'b0, m[NIB_W-1:0]} + (NIB_W+1)'(brw));
        dres   = bdiff[DATA_W-1:0]
               - (wrap   ? DATA_W'(96) : '0)
               - (lo_neg ? DATA_W'(6)  : '0);
        y.res  = dec ? dres : bdiff[DATA_W-1:0];
        y.v    = (a[DATA_W-1] ^ bdiff[DATA_W-1]) & (a[DATA_W-1] ^ m[DATA_W-1]);
        y.c    = ~wrap;
        y.n    = y.res[DATA_W-1];
        y.z    = (y.res == '0);
    end
endmodule

// File: rtl/alu_misc_unit.sv
// Bit test, accumulator increment and decrement.
// Assumes the caller masks the flags each operation does not own.
module alu_misc_unit
    import alu_bcd_pkg::*;
(
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] m,
    output alu_out_t          y
);
    // Result and candidate flags for the non-arithmetic operations.
    always_comb begin
        unique case (op)
            OP_INC:  y.res = a + DATA_W'(1);
            OP_DEC:  y.res = a - DATA_W'(1);
            default: y.res = a;
        endcase
        y.c = 1'b0;
        if (op == OP_BIT) begin
            y.n = m[DATA_W-1];
            y.v = m[DATA_W-2];
            y.z = ((a & m) == '0);
        end else begin
            y.n = y.res[DATA_W-1];
            y.v = 1'b0;
            y.z = (y.res == '0);
        end
    end
endmodule

// File: rtl/alu_bcd_core.sv
// Top: selects the unit bundle for the op, masks flags per op, and
// registers everything on start with a one-cycle valid pulse.
// Assumes start is a single-cycle strobe; outputs hold between strobes.
module alu_bcd_core
    import alu_bcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op,
    input  logic [7:0]        acc,
    input  logic [7:0]        opnd,
    input  logic              carry_in,
    input  logic              dec_mode,
    input  logic              imm_mode,
    output logic [7:0]        res,
    output logic              flag_n,
    output logic              flag_v,
    output logic              flag_z,
    output logic              flag_c,
    output logic              upd_n,
    output logic              upd_v,
    output logic              upd_z,
    output logic              upd_c,
    output logic              res_valid
);
    alu_out_t   add_y, sub_y, misc_y, sel_y;
    logic [3:0] en;

    alu_add_unit u_add (.a(acc), .m(opnd), .cin(carry_in), .dec(dec_mode), .y(add_y));
    alu_sub_unit u_sub (.a(acc), .m(opnd), .cin(carry_in), .dec(dec_mode), .y(sub_y));
    alu_misc_unit u_misc (.op(op), .a(acc), .m(opnd), .y(misc_y));

    // Pick the unit bundle and the flag enables {n,v,z,c} for the op.
    always_comb begin
        unique case (op)
            OP_ADD:         begin sel_y = add_y;  en = 4'b1111; end
            OP_SUB:         begin sel_y = sub_y;  en = 4'b1111; end
            OP_BIT:         begin sel_y = misc_y; en = imm_mode ? 4'b0010 : 4'b1110; end
            OP_INC, OP_DEC: begin sel_y = misc_y; en = 4'b1010; end
            default:        begin sel_y = misc_y; en = 4'b0000; end
        endcase
    end

    // Output register: capture on start, pulse valid, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res <= '0; flag_n <= 1'b0; flag_v <= 1'b0; flag_z <= 1'b0; flag_c <= 1'b0;
            upd_n <= 1'b0; upd_v <= 1'b0; upd_z <= 1'b0; upd_c <= 1'b0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= start;
            if (start) begin
                res    <= sel_y.res;
                flag_n <= sel_y.n & en[3];
                flag_v <= sel_y.v & en[2];
                flag_z <= sel_y.z & en[1];
                flag_c <= sel_y.c & en[0];
                {upd_n, upd_v, upd_z, upd_c} <= en;
            end
        end
    end

    p_valid_after_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> res_valid);
    p_idle_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (!res_valid && $stable(res) && $stable(flag_z) && $stable(upd_z)));
    p_bit_imm_only_z_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(op) == OP_BIT && $past(imm_mode)) |-> (!upd_n && !upd_v && !upd_c && upd_z));
    p_incdec_nz_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && ($past(op) == OP_INC || $past(op) == OP_DEC)) |-> (!upd_v && !upd_c));
    p_zero_tracks_res_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && upd_z && $past(op) != OP_BIT) |-> (flag_z == (res == 8'h00)));
    p_bcd_digits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(op) == OP_ADD && $past(dec_mode)
         && $past(acc[3:0]) <= 4'd9 && $past(acc[7:4]) <= 4'd9
         && $past(opnd[3:0]) <= 4'd9 && $past(opnd[7:4]) <= 4'd9)
        |-> (res[3:0] <= 4'd9 && res[7:4] <= 4'd9));
endmodule

// File: tb/sim_alu_bcd_core.sv
module sim_alu_bcd_core;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2:0] op = '0;
    logic [7:0] acc = '0, opnd = '0;
    logic carry_in = 1'b0, dec_mode = 1'b0, imm_mode = 1'b0;
    logic [7:0] res;
    logic flag_n, flag_v, flag_z, flag_c, upd_n, upd_v, upd_z, upd_c, res_valid;
    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    alu_bcd_core u0 (.clk(clk), .rst_n(rst_n), .start(start), .op(op), .acc(acc),
        .opnd(opnd), .carry_in(carry_in), .dec_mode(dec_mode), .imm_mode(imm_mode),
        .res(res), .flag_n(flag_n), .flag_v(flag_v), .flag_z(flag_z), .flag_c(flag_c),
        .upd_n(upd_n), .upd_v(upd_v), .upd_z(upd_z), .upd_c(upd_c), .res_valid(res_valid));

    // Expected {res, n, v, z, c, un, uv, uz, uc} from the requirement formulas.
    function automatic logic [15:0] model(int o, int a, int m, bit c, bit d, bit imm);
        int r, t, t2, lo, hi;
        bit n = 0, v = 0, z = 0, cc = 0, un = 0, uv = 0, uz = 0, uc = 0;
        r = a;
        case (o)
            0: begin
                if (d) begin
                    lo = (a & 15) + (m & 15) + c;
                    hi = (a & 240) + (m & 240);
                    if (lo > 9) begin hi += 16; lo += 6; end
                    v = ((~(a ^ m)) & (a ^ hi) & 128) != 0;
                    if (hi > 144) hi += 96;
                    cc = hi >= 256;
                    r = ((lo & 15) + (hi & 240)) & 255;
                end else begin
                    t = a + m + c;
                    v = ((~(a ^ m)) & (a ^ t) & 128) != 0;
                    cc = t > 255;
                    r = t & 255;
                end
                un = 1; uv = 1; uz = 1; uc = 1;
                n = r[7]; z = (r == 0);
            end
            1: begin
                t = (a - m - (c ? 0 : 1)) & 65535;
                v = ((a ^ t) & (a ^ m) & 128) != 0;
                if (d) begin
                    if (t > 255) t = (t - 96) & 65535;
                    t2 = ((a & 15) - (m & 15) - (c ? 0 : 1)) & 65535;
                    if (t2 > 255) t -= 6;
                end
                cc = (a - (c ? 0 : 1)) >= m;
                r = t & 255;
                un = 1; uv = 1; uz = 1; uc = 1;
                n = r[7]; z = (r == 0);
            end
            2: begin
                z = (a & m) == 0; uz = 1;
                if (!imm) begin n = m[7]; v = m[6]; un = 1; uv = 1; end
            end
            3: begin r = (a + 1) & 255; un = 1; uz = 1; n = r[7]; z = (r == 0); end
            4: begin r = (a + 255) & 255; un = 1; uz = 1; n = r[7]; z = (r == 0); end
            default: ;
        endcase
        return {r[7:0], n, v, z, cc, un, uv, uz, uc};
    endfunction

    function automatic string tag_of(int o, bit d, bit imm);
        case (o)
            0: return d ? "R2 R3 R9" : "R1 R9";
            1: return d ? "R5 R9" : "R4 R9";
            2: return imm ? "R7" : "R6";
            3, 4: return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic check(bit ok, string req, logic [15:0] act, logic [15:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] outs();
        return {res, flag_n, flag_v, flag_z, flag_c, upd_n, upd_v, upd_z, upd_c};
    endfunction

    // One strobed op, result check, then an idle cycle with a hold check.
    task automatic run_op(int o, int a, int m, bit c, bit d, bit imm);
        logic [15:0] exp;
        exp = model(o, a, m, c, d, imm);
        @(negedge clk);
        op = 3'(o); acc = 8'(a); opnd = 8'(m); carry_in = c; dec_mode = d; imm_mode = imm;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(res_valid === 1'b1, "R11 valid", {15'b0, res_valid}, 16'h1);
        check(outs() === exp, tag_of(o, d, imm), outs(), exp);
        acc = ~acc; opnd = ~opnd; op = 3'(o + 1);
        @(negedge clk);
        check(res_valid === 1'b0 && outs() === exp, "R11 hold", outs(), exp);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        check(outs() === 16'h0 && res_valid === 1'b0, "R12 reset", outs(), 16'h0);
        rst_n = 1'b1;
        // Directed corners
        run_op(0, 8'hFF, 8'h01, 0, 0, 0);   // R1 wrap to zero with carry
        run_op(0, 8'h50, 8'h50, 0, 0, 0);   // R1 signed overflow
        run_op(0, 8'h99, 8'h01, 0, 1, 0);   // R2 decimal carry out
        run_op(0, 8'h58, 8'h46, 1, 1, 0);   // R2 both digits corrected
        run_op(0, 8'h79, 8'h00, 1, 1, 0);   // R3 overflow from low carry
        run_op(0, 8'h99, 8'h99, 1, 1, 0);   // R2 largest decimal sum
        run_op(0, 8'hFA, 8'hFB, 0, 1, 0);   // R2 non-decimal operands
        run_op(1, 8'h00, 8'h01, 1, 0, 0);   // R4 borrow out
        run_op(1, 8'h80, 8'h01, 1, 0, 0);   // R4 signed overflow
        run_op(1, 8'h00, 8'h00, 0, 0, 0);   // R4 borrow in from zero
        run_op(1, 8'h00, 8'h01, 1, 1, 0);   // R5 decimal wrap to 99
        run_op(1, 8'h10, 8'h01, 1, 1, 0);   // R5 low digit borrow
        run_op(1, 8'h10, 8'h0B, 1, 1, 0);   // R5 non-decimal digit
        run_op(2, 8'h0F, 8'hC0, 0, 0, 0);   // R6 zero, N and V from operand
        run_op(2, 8'h0F, 8'hC0, 0, 0, 1);   // R7 immediate: Z only
        run_op(2, 8'hFF, 8'h41, 1, 0, 1);   // R7 nonzero AND
        run_op(3, 8'hFF, 8'h00, 0, 0, 0);   // R8 increment wraps
        run_op(4, 8'h00, 8'h00, 0, 0, 0);   // R8 decrement wraps
        run_op(4, 8'h01, 8'h00, 1, 1, 0);   // R8 decrement to zero
        for (int k = 5; k < 8; k++) run_op(k, 8'hA5, 8'h3C, 1, 1, 0);  // R10
        // Random mix
        for (int i = 0; i < 3000; i++) begin
            run_op(int'($urandom_range(0, 7)), int'($urandom_range(0, 255)),
                   int'($urandom_range(0, 255)), 1'($urandom), 1'($urandom), 1'($urandom));
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule